// File: doc/BRIEF.md
# Shadow ROM Region Attribute Decoder

This block decides, for every access into the legacy upper-memory window, whether the access is served by internal DRAM (shadowed) or passed on to the external bus. Reads and writes are steered separately. The window from 0xC0000 to 0xEFFFF is cut into twelve 16 KB segments. The top 64 KB, from 0xF0000 to 0xFFFFF, is one segment. Each segment owns a read-attribute bit and a write-attribute bit. These bits live in four 8-bit configuration registers, loaded through a plain byte-write port and visible through a byte read-back port.

Decoding is combinational from the current register contents. An access presents its address and a write flag. The block returns the read and write attributes of the matching segment and the route for this access. It also gives a range flag for addresses below the window. A separate summary flag reports whether any segment in the BIOS area (0xE0000 and up) has read shadowing enabled. There is no streamed data and no back-pressure. Every pin is a plain level-sensitive control or status signal, and a configuration write always completes in the cycle it is presented.

Top module: `shadow_region_decoder`

## Requirements
- R1: Let the four registers be concatenated as a 32-bit vector with register 0 in bits 7:0 and register 3 in bits 31:24. An address in segment i (i = 0..11, segment base 0xC0000 + i*0x4000) takes its read attribute from vector bit 2i+4 and its write attribute from vector bit 2i+5.
- R2: Any address from 0xF0000 to 0xFFFFF takes its read attribute from bit 4 and its write attribute from bit 5 of register 3.
- R3: `rd_int` is 1 when the segment's read bit is set and 0 when it is clear, where 0 means the external bus. `wr_int` follows the write bit in the same way. `route_int` equals `wr_int` when `acc_write` is 1 and equals `rd_int` otherwise.
- R4: Bits 7:6 of register 3 ignore written values and always read back as 0.
- R5: `bios_shadow` is 1 exactly when at least one read bit of a segment at or above 0xE0000 is set. These are vector bits 20, 22, 24, 26 and 28.
- R6: After reset all four registers read 0, so every segment routes to the external bus and `bios_shadow` is 0.
- R7: Bits 3:0 of register 0 are stored and read back unchanged, and they have no effect on any decode output.
- R8: An address below 0xC0000 drives `out_of_range` to 1 and drives `rd_int`, `wr_int` and `route_int` to 0. Inside the window, `out_of_range` is 0.
- R9: A write with `cfg_we` high updates register `cfg_waddr` at the clock edge, and read-back and decode reflect the new value from that edge on. With `cfg_we` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_waddr | input | 2 | Register selected for writing |
| cfg_wdata | input | 8 | Byte to write |
| cfg_raddr | input | 2 | Register selected for read-back |
| cfg_rdata | output | 8 | Read-back byte |
| acc_addr | input | 20 | Access address |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| rd_int | output | 1 | Read attribute of the addressed segment (1 = internal DRAM) |
| wr_int | output | 1 | Write attribute of the addressed segment (1 = internal DRAM) |
| route_int | output | 1 | Route of this access (1 = internal DRAM) |
| out_of_range | output | 1 | Address lies below the decoded window |
| bios_shadow | output | 1 | Some BIOS-area segment has read shadowing enabled |

## Verification
The bench builds the block with its default parameters: a 20-bit address, a 0xC0000 window base, 16 KB small segments, twelve of them, and four registers. These values put every segment edge within reach, including the clamp that merges the last four 16 KB slots into the 64 KB top segment. They also cover the 0xBFFFF/0xC0000 boundary and the locked top bits of register 3. Random writes and random addresses biased into the window exercise the bit packing across all four bytes.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  typedef logic [7:0] cfg_byte_t;

  // Mask of writable bits for register number r out of n registers.
  function automatic cfg_byte_t writable_mask(input int r, input int n, input cfg_byte_t last_mask);
    return (r == n - 1) ? last_mask : 8'hFF;
  endfunction
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_pkg::*;
#(
  parameter int N_REGS    = 4,
  parameter logic [7:0] LAST_MASK = 8'h3F,
  localparam int SEL_W    = $clog2(N_REGS),
  localparam int CFG_W    = 8 * N_REGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] waddr,
  input  cfg_byte_t        wdata,
  input  logic [SEL_W-1:0] raddr,
  output cfg_byte_t        rdata,
  output logic [CFG_W-1:0] bits
);
  cfg_byte_t regs [N_REGS];

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    localparam cfg_byte_t MASK = writable_mask(r, N_REGS, LAST_MASK);
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[r] <= '0;
      else if (we && waddr == SEL_W'(r))
        regs[r] <= wdata & MASK;
    end
    assign bits[8*r +: 8] = regs[r];
  end

  assign rdata = regs[raddr];

  // R4: locked bits of the last register never hold a one
  a_r4_locked_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[N_REGS-1] & ~LAST_MASK) == 8'h00);

  // R9: a presented write is visible on read-back after the edge
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && raddr == waddr) |=> rdata == ($past(wdata) & writable_mask(int'($past(waddr)), N_REGS, LAST_MASK)));
endmodule

// File: rtl/shadow_seg_index.sv
module shadow_seg_index #(
  parameter int ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hC0000,
  parameter int SEG_SHIFT = 14,
  parameter int N_SMALL   = 12,
  localparam int N_SEGS   = N_SMALL + 1,
  localparam int IDX_W    = $clog2(N_SEGS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_range,
  output logic [IDX_W-1:0]  seg_idx
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] slot;

  always_comb begin
    in_range = (addr >= WIN_BASE);
    offset   = addr - WIN_BASE;
    slot     = offset >> SEG_SHIFT;
    if (!in_range)
      seg_idx = '0;
    else if (slot >= ADDR_W'(N_SMALL))
      seg_idx = IDX_W'(N_SMALL);
    else
      seg_idx = slot[IDX_W-1:0];
  end
endmodule

// File: rtl/shadow_attr_mux.sv
module shadow_attr_mux #(
  parameter int N_SMALL    = 12,
  parameter int BIT_OFS    = 4,
  parameter int BIOS_FIRST = 8,
  parameter int CFG_W      = 32,
  localparam int N_SEGS    = N_SMALL + 1,
  localparam int IDX_W     = $clog2(N_SEGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] bits,
  input  logic             in_range,
  input  logic [IDX_W-1:0] seg_idx,
  input  logic             acc_write,
  output logic             rd_int,
  output logic             wr_int,
  output logic             route_int,
  output logic             bios_shadow
);
  logic [N_SEGS-1:0] rd_vec;
  logic [N_SEGS-1:0] wr_vec;

  for (genvar s = 0; s < N_SEGS; s++) begin : g_seg
    assign rd_vec[s] = bits[2*s + BIT_OFS];
    assign wr_vec[s] = bits[2*s + BIT_OFS + 1];
  end

  always_comb begin
    rd_int      = 1'b0;
    wr_int      = 1'b0;
    for (int s = 0; s < N_SEGS; s++) begin
      if (in_range && seg_idx == IDX_W'(s)) begin
        rd_int = rd_vec[s];
        wr_int = wr_vec[s];
      end
    end
    route_int   = acc_write ? wr_int : rd_int;
    bios_shadow = |rd_vec[N_SEGS-1:BIOS_FIRST];
  end

  // R5: with the summary flag low, no BIOS-area access can read internally
  a_r5_summary_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (!bios_shadow && in_range && seg_idx >= IDX_W'(BIOS_FIRST)) |-> !rd_int);

  // R3: an internal route always comes from an internal attribute
  a_r3_route_source: assert property (@(posedge clk) disable iff (!rst_n)
    route_int |-> (rd_int || wr_int));
endmodule

// File: rtl/shadow_region_decoder.sv
module shadow_region_decoder
  import shadow_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hC0000,
  parameter int SEG_SHIFT  = 14,
  parameter int N_SMALL    = 12,
  parameter int N_REGS     = 4,
  parameter int BIT_OFS    = 4,
  parameter int BIOS_FIRST = 8,
  parameter logic [7:0] LAST_MASK = 8'h3F,
  localparam int SEL_W     = $clog2(N_REGS),
  localparam int CFG_W     = 8 * N_REGS,
  localparam int IDX_W     = $clog2(N_SMALL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_waddr,
  input  logic [7:0]        cfg_wdata,
  input  logic [SEL_W-1:0]  cfg_raddr,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              rd_int,
  output logic              wr_int,
  output logic              route_int,
  output logic              out_of_range,
  output logic              bios_shadow
);
  logic [CFG_W-1:0] cfg_bits;
  logic             in_range;
  logic [IDX_W-1:0] seg_idx;

  shadow_cfg_regs #(.N_REGS(N_REGS), .LAST_MASK(LAST_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .rdata(cfg_rdata), .bits(cfg_bits)
  );

  shadow_seg_index #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .SEG_SHIFT(SEG_SHIFT),
                     .N_SMALL(N_SMALL)) u_index (
    .addr(acc_addr), .in_range(in_range), .seg_idx(seg_idx)
  );

  shadow_attr_mux #(.N_SMALL(N_SMALL), .BIT_OFS(BIT_OFS), .BIOS_FIRST(BIOS_FIRST),
                    .CFG_W(CFG_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .bits(cfg_bits), .in_range(in_range), .seg_idx(seg_idx),
    .acc_write(acc_write), .rd_int(rd_int), .wr_int(wr_int), .route_int(route_int),
    .bios_shadow(bios_shadow)
  );

  assign out_of_range = !in_range;

  // R8: addresses under the window are never routed internally
  a_r8_below_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr < WIN_BASE) |-> (out_of_range && !rd_int && !wr_int && !route_int));
endmodule

// File: tb/shadow_region_decoder_bench.sv
module shadow_region_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_waddr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [1:0]  cfg_raddr = '0;
  logic [7:0]  cfg_rdata;
  logic [19:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        rd_int, wr_int, route_int, out_of_range, bios_shadow;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [4];

  always #2 clk = ~clk;

  shadow_region_decoder u_shadow_region_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr), .acc_write(acc_write),
    .rd_int(rd_int), .wr_int(wr_int), .route_int(route_int), .out_of_range(out_of_range),
    .bios_shadow(bios_shadow)
  );

  function automatic logic [31:0] vec();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  function automatic int seg_of(input logic [19:0] a);
    int s;
    if (a < 20'hC0000) return -1;
    s = int'((a - 20'hC0000) >> 14);
    return (s > 12) ? 12 : s;
  endfunction

  function automatic logic exp_rd(input logic [19:0] a);
    int s = seg_of(a);
    logic [31:0] v = vec();
    return (s < 0) ? 1'b0 : v[2*s + 4];
  endfunction

  function automatic logic exp_wr(input logic [19:0] a);
    int s = seg_of(a);
    logic [31:0] v = vec();
    return (s < 0) ? 1'b0 : v[2*s + 5];
  endfunction

  function automatic logic exp_bios();
    logic [31:0] v = vec();
    return v[20] | v[22] | v[24] | v[26] | v[28];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] r, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = r; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model[r] = (r == 2'd3) ? (d & 8'h3F) : d;
  endtask

  task automatic probe(input string req, input logic [19:0] a, input logic w);
    @(negedge clk);
    acc_addr = a; acc_write = w;
    #1;
    check({req, " rd"}, 32'(rd_int), 32'(exp_rd(a)));
    check({req, " wr"}, 32'(wr_int), 32'(exp_wr(a)));
    check({req, " route"}, 32'(route_int), 32'(w ? exp_wr(a) : exp_rd(a)));
    check({req, " oor"}, 32'(out_of_range), 32'(a < 20'hC0000));
    check({req, " bios"}, 32'(bios_shadow), 32'(exp_bios()));
  endtask

  task automatic readback(input string req, input logic [1:0] r);
    @(negedge clk);
    cfg_raddr = r;
    #1;
    check(req, 32'(cfg_rdata), 32'(model[r]));
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [7:0]  keep;
    seed = 32'd20251;
    void'($urandom(seed));
    for (int r = 0; r < 4; r++) model[r] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: reset state
    for (int r = 0; r < 4; r++) readback("R6 reset readback", 2'(r));
    probe("R6 reset top", 20'hFFFFF, 1'b0);
    probe("R6 reset mid", 20'hD4000, 1'b1);

    // R8: below the window, even with everything enabled
    for (int r = 0; r < 4; r++) wr_reg(2'(r), 8'hFF);
    probe("R8 below", 20'hBFFFF, 1'b0);
    probe("R8 below", 20'h00000, 1'b1);
    probe("R8 edge", 20'hC0000, 1'b0);

    // R4: locked top bits of register 3
    readback("R4 reg3 locked", 2'd3);
    wr_reg(2'd3, 8'hC0);
    readback("R4 reg3 only top", 2'd3);

    // R2: top 64 KB segment uses reg3 bits 4/5
    for (int r = 0; r < 4; r++) wr_reg(2'(r), 8'h00);
    wr_reg(2'd3, 8'h10);
    probe("R2 top rd", 20'hF0000, 1'b0);
    probe("R2 top rd", 20'hFFFFF, 1'b1);
    wr_reg(2'd3, 8'h20);
    probe("R2 top wr", 20'hFC000, 1'b1);
    probe("R2 neighbour", 20'hEFFFF, 1'b1);

    // R1: walk each small segment with single bits
    for (int s = 0; s < 12; s++) begin
      logic [31:0] v;
      v = 32'h1 << (2*s + 4 + (s % 2));
      for (int r = 0; r < 4; r++) wr_reg(2'(r), v[8*r +: 8]);
      probe("R1 seg lo", 20'hC0000 + 20'(s) * 20'h4000, 1'b0);
      probe("R1 seg hi", 20'hC3FFF + 20'(s) * 20'h4000, 1'b1);
    end

    // R5: each BIOS-area read bit alone, plus a write bit that must not count
    for (int b = 20; b <= 28; b += 2) begin
      logic [31:0] v;
      v = 32'h1 << b;
      for (int r = 0; r < 4; r++) wr_reg(2'(r), v[8*r +: 8]);
      probe("R5 bios bit", 20'hE0000, 1'b0);
    end
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd2, 8'h20);
    probe("R5 write bit only", 20'hE4000, 1'b1);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd1, 8'hFF);
    probe("R5 below E0000", 20'hD0000, 1'b0);

    // R7: spare low bits of register 0
    for (int r = 0; r < 4; r++) wr_reg(2'(r), 8'h00);
    wr_reg(2'd0, 8'h0F);
    readback("R7 spare readback", 2'd0);
    probe("R7 no decode c0", 20'hC0000, 1'b0);
    probe("R7 no decode c0w", 20'hC2000, 1'b1);

    // R9: write enable low leaves registers alone
    @(negedge clk);
    cfg_we = 1'b0; cfg_waddr = 2'd1; cfg_wdata = 8'hAA;
    @(negedge clk);
    readback("R9 no write", 2'd1);

    // R1 R3 R9: random writes and accesses
    for (int n = 0; n < 400; n++) begin
      logic [19:0] a;
      keep = 8'($urandom);
      wr_reg(2'($urandom), keep);
      readback("R9 random readback", 2'($urandom));
      a = ($urandom % 8 == 0) ? 20'($urandom) : (20'hC0000 + 20'($urandom % 20'h40000));
      probe("R3 random", a, 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule